// File: doc/BRIEF.md
# Clock Output Pin Controller

This block decides what appears on a shared pin that can carry the internal system clock to the outside world. Software controls the pin with two register bits. A direction bit turns the pin into an output. A stop bit freezes the clock on that output. The processor's power-state sequencer supplies the current processing state. The block returns a pin value and an output enable for the pad.

A stop or restart request never cuts a clock pulse short. The request is captured only on a rising clock edge where the bus interface flags the end of a bus cycle. The stopped level is high. Gating uses an OR gate fed by a latch that is open while the clock is high, so the pin can only settle into, or leave, the held-high level during a high phase. In the deep power states the pin is either held high or released, as set by the direction bit and the state. Undefined state codes are handled as the deepest state.

Top module: `clkout_pin_ctl`

## Requirements
- R1: With `dir_out` = 0, `pin_oe` is 0 for every `pstate` code and every stop setting.
- R2: `pstate` codes 5 (hardware standby), 6 and 7 (unused) give `pin_oe` = 0 whatever the register bits are.
- R3: With `dir_out` = 1, `pstate` 0 (active: high-speed, medium-speed or subactive) or 1 (sleep or subsleep), and the output running, `pin_oe` = 1 and `pin_o` follows the system clock: 1 in the high phase and 0 in the low phase.
- R4: `stop_req` = 1 sampled on a rising edge together with `bus_end` = 1 stops the output from that edge on. In states 0 and 1 the pin then stays at 1 through both clock phases.
- R5: While `bus_end` is 0, a change of `stop_req` has no effect on the pin.
- R6: `stop_req` = 0 sampled on a rising edge together with `bus_end` = 1 restarts the output. The pin holds 1 for the rest of that high phase and then follows the clock, so there is no shortened pulse.
- R7: `pstate` codes 2 (software standby), 3 (watch) and 4 (direct transition) with `dir_out` = 1 give `pin_oe` = 1 and `pin_o` = 1 in both clock phases, whether the output is stopped or running.
- R8: Whenever `pin_oe` is 0, `pin_o` is 0.
- R9: After reset the output is running. With `dir_out` = 1 and `pstate` 0 the clock appears on the pin.
- R10: A stop captured earlier stays in force across `pstate` changes. It ends only through a restart as in R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal system clock, both the source and the register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stop_req | input | 1 | Clock-stop register bit (1 = stop request) |
| dir_out | input | 1 | Direction bit of the shared pin (1 = output) |
| bus_end | input | 1 | High in the last cycle of a bus cycle |
| pstate | input | 3 | Encoded processing state (0 active, 1 sleep, 2 sw standby, 3 watch, 4 direct transition, 5 hw standby, 6-7 unused) |
| pin_o | output | 1 | Value driven onto the pin |
| pin_oe | output | 1 | Pad output enable (0 = high impedance) |

## Verification
The only internal state is the run/stop flag and its latched copy. A wrong value shows up in states 0 and 1 within one clock phase. The symptom is either a pin stuck high during the low phase while it should be running, or a pin that toggles while it should be held. The bench sweeps every direction, state and stop combination. It samples the middle of both phases, so a state decode error is visible in the first cycle after the state is applied. The edge-by-edge stop and restart sequences expose a flag that updates without `bus_end` or a phase that has been shortened.

// File: rtl/clkout_pkg.sv
// Package for the clock output pin controller.
// Holds the processing-state codes shared by the design and its checker.
package clkout_pkg;
    localparam int PSTATE_W = 3;

    typedef enum logic [PSTATE_W-1:0] {
        PS_ACTIVE = 3'd0,
        PS_SLEEP  = 3'd1,
        PS_SWSTBY = 3'd2,
        PS_WATCH  = 3'd3,
        PS_DTRANS = 3'd4,
        PS_HWSTBY = 3'd5
    } pstate_e;
endpackage

// File: rtl/clkout_stop_sync.sv
// Run/stop flag for the clock output.
// Takes a new value of the stop request only on edges that close a bus cycle.
// Assumes bus_end is synchronous to clk.
module clkout_stop_sync #(
    parameter logic RESET_RUN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic bus_end,
    output logic run_en
);
    // Capture the inverted stop request at bus-cycle boundaries only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_en <= RESET_RUN;
        else if (bus_end)
            run_en <= ~stop_req;
    end
endmodule

// File: rtl/clkout_gate.sv
// Glitch-free gate that holds the clock high when disabled.
// The enable passes through a latch that is open only while clk is high.
// Enable changes therefore reach the OR gate only while its output is already 1.
module clkout_gate (
    input  logic clk,
    input  logic run_en,
    output logic clk_gated
);
    logic en_lat;

    // Pass the enable only during the high phase.
    always_latch begin
        if (clk)
            en_lat = run_en;
    end

    // A disabled gate forces a steady high.
    always_comb clk_gated = clk | ~en_lat;
endmodule

// File: rtl/clkout_pin_mux.sv
// Selects the pin value and output enable.
// The inputs are the direction bit, the processing state and the gated clock.
// Codes outside the package enum are handled as hardware standby.
module clkout_pin_mux
    import clkout_pkg::*;
(
    input  logic                clk_gated,
    input  logic                dir_out,
    input  logic [PSTATE_W-1:0] pstate,
    output logic                pin_o,
    output logic                pin_oe
);
    // Decode the state into release / fixed-high / clock.
    always_comb begin
        pin_oe = 1'b0;
        pin_o  = 1'b0;
        if (dir_out) begin
            case (pstate)
                PS_ACTIVE, PS_SLEEP: begin
                    pin_oe = 1'b1;
                    pin_o  = clk_gated;
                end
                PS_SWSTBY, PS_WATCH, PS_DTRANS: begin
                    pin_oe = 1'b1;
                    pin_o  = 1'b1;
                end
                default: begin
                    pin_oe = 1'b0;
                    pin_o  = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/clkout_pin_ctl.sv
// Top of the clock output pin controller.
// Connects the boundary-synchronised run flag, the hold-high gate and the state mux.
// Assumes all control inputs are synchronous to clk.
module clkout_pin_ctl
    import clkout_pkg::*;
#(
    parameter logic RESET_RUN = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                stop_req,
    input  logic                dir_out,
    input  logic                bus_end,
    input  logic [PSTATE_W-1:0] pstate,
    output logic                pin_o,
    output logic                pin_oe
);
    logic run_en;
    logic clk_gated;

    clkout_stop_sync #(.RESET_RUN(RESET_RUN)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_req (stop_req),
        .bus_end  (bus_end),
        .run_en   (run_en)
    );

    clkout_gate u_gate (
        .clk       (clk),
        .run_en    (run_en),
        .clk_gated (clk_gated)
    );

    clkout_pin_mux u_mux (
        .clk_gated (clk_gated),
        .dir_out   (dir_out),
        .pstate    (pstate),
        .pin_o     (pin_o),
        .pin_oe    (pin_oe)
    );
endmodule

// File: rtl/clkout_pin_ctl_chk.sv
// Checker for clkout_pin_ctl, attached with bind.
// Relates the port values to the run flag kept by the sync stage.
module clkout_pin_ctl_chk
    import clkout_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                stop_req,
    input logic                dir_out,
    input logic                bus_end,
    input logic [PSTATE_W-1:0] pstate,
    input logic                pin_o,
    input logic                pin_oe,
    input logic                run_en
);
    // R1
    dir_in_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_out |-> !pin_oe);
    // R2
    hw_standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pstate >= 3'd5) |-> !pin_oe);
    // R7
    standby_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out && pstate >= 3'd2 && pstate <= 3'd4) |-> (pin_oe && pin_o));
    // R8
    hiz_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !pin_o);
    // R4
    stop_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_end && stop_req) |=> !run_en);
    // R6
    restart_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_end && !stop_req) |=> run_en);
    // R5
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_end |=> $stable(run_en));
endmodule

bind clkout_pin_ctl clkout_pin_ctl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_req (stop_req),
    .dir_out  (dir_out),
    .bus_end  (bus_end),
    .pstate   (pstate),
    .pin_o    (pin_o),
    .pin_oe   (pin_oe),
    .run_en   (run_en)
);

// File: tb/clkout_pin_ctl_tb.sv
// Bench for clkout_pin_ctl.
// Sweeps all direction, state and stop combinations, then walks through the stop and restart edges.
module clkout_pin_ctl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stop_req = 1'b0;
    logic       dir_out = 1'b0;
    logic       bus_end = 1'b0;
    logic [2:0] pstate = 3'd0;
    logic       pin_o;
    logic       pin_oe;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    clkout_pin_ctl u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .stop_req (stop_req),
        .dir_out  (dir_out),
        .bus_end  (bus_end),
        .pstate   (pstate),
        .pin_o    (pin_o),
        .pin_oe   (pin_oe)
    );

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0b expected %0b", req, got, exp);
        end
    endtask

    // Capture a stop setting through one bus-cycle end; inputs change at a negedge.
    task automatic apply_stop(input logic s);
        @(negedge clk);
        stop_req = s;
        bus_end  = 1'b1;
        @(negedge clk);
        bus_end  = 1'b0;
    endtask

    // Sample mid-high (posedge+2) and mid-low (posedge+6).
    task automatic sample(output logic hi_o, output logic hi_oe,
                          output logic lo_o, output logic lo_oe);
        @(posedge clk);
        #2;
        hi_o = pin_o;
        hi_oe = pin_oe;
        #4;
        lo_o = pin_o;
        lo_oe = pin_oe;
    endtask

    initial begin
        #(200000 * 8);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic ho, hoe, lo, loe;
        logic exp_oe, exp_lo;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        dir_out = 1'b1;
        pstate = 3'd0;
        // R9: running out of reset
        sample(ho, hoe, lo, loe);
        chk("R9 oe", hoe, 1'b1);
        chk("R9 high phase", ho, 1'b1);
        chk("R9 low phase", lo, 1'b0);

        // Sweep: R1 R2 R3 R4 R7 R8
        for (int s = 0; s < 2; s++) begin
            apply_stop(s[0]);
            for (int d = 0; d < 2; d++) begin
                for (int st = 0; st < 8; st++) begin
                    @(negedge clk);
                    dir_out = d[0];
                    pstate = st[2:0];
                    sample(ho, hoe, lo, loe);
                    exp_oe = d[0] && (st < 5);
                    exp_lo = exp_oe && ((st >= 2) || s[0]);
                    if (!d[0]) chk("R1 oe", hoe, 1'b0);
                    else if (st >= 5) chk("R2 oe", hoe, 1'b0);
                    else chk("R3/R7 oe", hoe, 1'b1);
                    chk("R8 high phase", ho, exp_oe);
                    if (exp_oe && st < 2) chk(s[0] ? "R4 low phase" : "R3 low phase", lo, exp_lo);
                    else if (exp_oe) chk("R7 low phase", lo, exp_lo);
                    else chk("R8 low phase", lo, exp_lo);
                    chk("R1/R2 low oe", loe, exp_oe);
                end
            end
        end

        // R5: stop request without bus_end is ignored
        @(negedge clk);
        dir_out = 1'b1;
        pstate = 3'd0;
        apply_stop(1'b0);
        @(negedge clk);
        stop_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            sample(ho, hoe, lo, loe);
            chk("R5 still running", lo, 1'b0);
        end

        // R4: takes effect at the capturing edge
        @(negedge clk);
        bus_end = 1'b1;
        #2;
        chk("R4 before edge", pin_o, 1'b0);
        @(posedge clk);
        #2;
        chk("R4 high after edge", pin_o, 1'b1);
        bus_end = 1'b0;
        #4;
        chk("R4 held in low phase", pin_o, 1'b1);

        // R5: clearing stop without bus_end is ignored
        stop_req = 1'b0;
        sample(ho, hoe, lo, loe);
        chk("R5 still stopped", lo, 1'b1);

        // R10: stop survives state changes
        @(negedge clk);
        pstate = 3'd3;
        sample(ho, hoe, lo, loe);
        @(negedge clk);
        pstate = 3'd1;
        sample(ho, hoe, lo, loe);
        chk("R10 stop kept", lo, 1'b1);

        // R6: restart with full phases
        @(negedge clk);
        stop_req = 1'b0;
        bus_end = 1'b1;
        #2;
        chk("R6 still held before edge", pin_o, 1'b1);
        @(posedge clk);
        #2;
        chk("R6 high after edge", pin_o, 1'b1);
        bus_end = 1'b0;
        #4;
        chk("R6 low phase resumes", pin_o, 1'b0);
        sample(ho, hoe, lo, loe);
        chk("R6 next high", ho, 1'b1);
        chk("R6 next low", lo, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule